// File: doc/BRIEF.md
# Execute Stage: Operand Selection, ALU, Flags and Branch Decision

This block is the execute step of a processor that completes one instruction per clock. The opcode picks what the two ALU operands are and which of four operations is applied. The choices are register value A, register value B, the instruction constant, a fixed stack step, or zero. The block drives the resulting word out combinationally, for use as an arithmetic result, a memory address or a new stack pointer.

A three-bit flag register holds zero, sign and signed overflow. It is written on the clock edge only when the instruction is an arithmetic/logic operation. A jump opcode compares its function code with these stored flags, so the branch decision always uses the flags left by an earlier arithmetic instruction. The flags produced in the same cycle are not used. The branch output tells the program-counter logic to take the jump target.

Top module: `exec_stage`

## Requirements
- R1: Opcode encoding is halt=0, nop=1, register move=2, immediate move=3, store=4, load=5, arithmetic=6, jump=7, call=8, return=9, push=10, pop=11; 12 to 15 act as nop. The first operand is register value A for codes 2 and 6, the constant for codes 3, 4 and 5, minus STEP for codes 8 and 10, plus STEP for codes 9 and 11, and zero otherwise.
- R2: The second operand is register value B for codes 4, 5, 6, 8, 9, 10 and 11, and zero for all other codes. Both move forms therefore output their first operand unchanged.
- R3: For opcode 6 the function code selects the operation: 0 gives B+A, 1 gives B−A, 2 gives B AND A, 3 gives B XOR A. Codes 4 to 15 give B+A.
- R4: Every opcode other than 6 adds. Store and load output B plus the constant. Call and push output B minus STEP. Return and pop output B plus STEP. All results wrap modulo 2^W.
- R5: On a clock edge with opcode 6, the flags are loaded from that cycle's result. Zero is set when the result is 0. Sign copies the result's top bit. Overflow is set when the signed add or subtract gives a result outside the signed W-bit range.
- R6: The AND and XOR operations always load overflow as 0.
- R7: A clock edge with any opcode other than 6 leaves all three flags unchanged.
- R8: A synchronous active-high reset sets zero to 1 and clears sign and overflow.
- R9: For opcode 7 the branch output is evaluated from the stored flags, with lt = sign XOR overflow. Function 0 is always taken, 1 when lt or zero, 2 when lt, 3 when zero, 4 when not zero, 5 when not lt, and 6 when neither lt nor zero.
- R10: The branch output is 0 for every opcode other than 7. For opcode 7 it is also 0 for function codes 7 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags update on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_code | input | 4 | Instruction opcode |
| fn_code | input | 4 | ALU operation code or jump condition code |
| reg_a | input | W | Register value A |
| reg_b | input | W | Register value B |
| const_val | input | W | Instruction constant |
| result | output | W | ALU result |
| take_branch | output | 1 | Jump condition met |

## Verification
The bench builds the block with W=8 and STEP=4. At that width the first operand can take every one of its 256 values, and the second operand can cover a 19-value set that includes 0, 1, 0x7F, 0x80 and 0xFF, for every ALU operation. That reaches every signed-overflow boundary and the zero-result cases, and a bench model in plain integer arithmetic predicts each result. After each arithmetic step, all 16 jump condition codes are tested against the flags the model predicts. Each non-arithmetic opcode is run across clock edges to show the stored flags survive.

// File: rtl/exec_pkg.sv
package exec_pkg;

    typedef enum logic [3:0] {
        OP_HALT  = 4'd0,
        OP_NOP   = 4'd1,
        OP_MOVRR = 4'd2,
        OP_MOVIR = 4'd3,
        OP_STORE = 4'd4,
        OP_LOAD  = 4'd5,
        OP_ALU   = 4'd6,
        OP_JUMP  = 4'd7,
        OP_CALL  = 4'd8,
        OP_RET   = 4'd9,
        OP_PUSH  = 4'd10,
        OP_POP   = 4'd11
    } opcode_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_XOR = 2'd3
    } alu_fn_e;

    typedef enum logic [2:0] {
        ASRC_ZERO,
        ASRC_REG,
        ASRC_CONST,
        ASRC_DEC,
        ASRC_INC
    } a_src_e;

    typedef enum logic {
        BSRC_ZERO,
        BSRC_REG
    } b_src_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

    localparam int NUM_FN_CODES = 16;

    typedef struct packed {
        a_src_e  a_src;
        b_src_e  b_src;
        alu_fn_e fn;
        logic    set_cc;
    } exec_ctrl_t;

    function automatic exec_ctrl_t decode_exec(logic [3:0] op, logic [3:0] fn);
        exec_ctrl_t c;
        c.a_src  = ASRC_ZERO;
        c.b_src  = BSRC_ZERO;
        c.fn     = FN_ADD;
        c.set_cc = 1'b0;
        case (op)
            OP_MOVRR: c.a_src = ASRC_REG;
            OP_MOVIR: c.a_src = ASRC_CONST;
            OP_STORE, OP_LOAD: begin
                c.a_src = ASRC_CONST;
                c.b_src = BSRC_REG;
            end
            OP_ALU: begin
                c.a_src  = ASRC_REG;
                c.b_src  = BSRC_REG;
                c.fn     = (fn < 4'd4) ? alu_fn_e'(fn[1:0]) : FN_ADD;
                c.set_cc = 1'b1;
            end
            OP_CALL, OP_PUSH: begin
                c.a_src = ASRC_DEC;
                c.b_src = BSRC_REG;
            end
            OP_RET, OP_POP: begin
                c.a_src = ASRC_INC;
                c.b_src = BSRC_REG;
            end
            default: ;
        endcase
        return c;
    endfunction

    function automatic logic eval_cond(flags_t f, logic [3:0] code);
        logic lt;
        logic taken;
        lt = f.sf ^ f.of;
        case (code)
            4'd0:    taken = 1'b1;
            4'd1:    taken = lt | f.zf;
            4'd2:    taken = lt;
            4'd3:    taken = f.zf;
            4'd4:    taken = ~f.zf;
            4'd5:    taken = ~lt;
            4'd6:    taken = ~(lt | f.zf);
            default: taken = 1'b0;
        endcase
        return taken;
    endfunction

endpackage

// File: rtl/exec_ctrl_dec.sv
module exec_ctrl_dec
    import exec_pkg::*;
(
    input  logic [3:0] op_code,
    input  logic [3:0] fn_code,
    output a_src_e     a_src,
    output b_src_e     b_src,
    output alu_fn_e    alu_fn,
    output logic       set_cc,
    output logic       is_jump
);

    exec_ctrl_t ctrl;

    always_comb begin
        ctrl    = decode_exec(op_code, fn_code);
        a_src   = ctrl.a_src;
        b_src   = ctrl.b_src;
        alu_fn  = ctrl.fn;
        set_cc  = ctrl.set_cc;
        is_jump = (op_code == OP_JUMP);
    end

endmodule

// File: rtl/exec_operand_sel.sv
module exec_operand_sel
    import exec_pkg::*;
#(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input  a_src_e       a_src,
    input  b_src_e       b_src,
    input  logic [W-1:0] reg_a,
    input  logic [W-1:0] reg_b,
    input  logic [W-1:0] const_val,
    output logic [W-1:0] alu_a,
    output logic [W-1:0] alu_b
);

    localparam logic [W-1:0] STEP_UP = W'(STEP);
    localparam logic [W-1:0] STEP_DN = '0 - STEP_UP;

    always_comb begin
        case (a_src)
            ASRC_REG:   alu_a = reg_a;
            ASRC_CONST: alu_a = const_val;
            ASRC_DEC:   alu_a = STEP_DN;
            ASRC_INC:   alu_a = STEP_UP;
            default:    alu_a = '0;
        endcase
    end

    always_comb begin
        case (b_src)
            BSRC_REG: alu_b = reg_b;
            default:  alu_b = '0;
        endcase
    end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import exec_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_fn_e      fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output flags_t       flags_next
);

    localparam int MSB = W - 1;

    logic [W-1:0] sum;
    logic [W-1:0] diff;
    logic         ovf_add;
    logic         ovf_sub;

    always_comb begin
        sum     = b + a;
        diff    = b - a;
        ovf_add = (a[MSB] == b[MSB]) && (sum[MSB] != b[MSB]);
        ovf_sub = (a[MSB] != b[MSB]) && (diff[MSB] != b[MSB]);
    end

    always_comb begin
        case (fn)
            FN_SUB: begin
                y             = diff;
                flags_next.of = ovf_sub;
            end
            FN_AND: begin
                y             = b & a;
                flags_next.of = 1'b0;
            end
            FN_XOR: begin
                y             = b ^ a;
                flags_next.of = 1'b0;
            end
            default: begin
                y             = sum;
                flags_next.of = ovf_add;
            end
        endcase
        flags_next.zf = (y == '0);
        flags_next.sf = y[MSB];
    end

endmodule

// File: rtl/exec_cc_branch.sv
module exec_cc_branch
    import exec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  flags_t     flags_next,
    input  logic       is_jump,
    input  logic [3:0] fn_code,
    output flags_t     cc_q,
    output logic       take_branch
);

    logic [NUM_FN_CODES-1:0] cond_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_q <= FLAGS_RESET;
        end else if (load) begin
            cc_q <= flags_next;
        end
    end

    for (genvar g = 0; g < NUM_FN_CODES; g++) begin : g_cond
        assign cond_vec[g] = eval_cond(cc_q, 4'(g));
    end

    assign take_branch = is_jump && cond_vec[fn_code];

endmodule

// File: rtl/exec_stage.sv
module exec_stage
    import exec_pkg::*;
#(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   op_code,
    input  logic [3:0]   fn_code,
    input  logic [W-1:0] reg_a,
    input  logic [W-1:0] reg_b,
    input  logic [W-1:0] const_val,
    output logic [W-1:0] result,
    output logic         take_branch
);

    a_src_e       a_src;
    b_src_e       b_src;
    alu_fn_e      alu_fn;
    logic         set_cc;
    logic         is_jump;
    logic [W-1:0] alu_a;
    logic [W-1:0] alu_b;
    flags_t       flags_next;
    flags_t       cc_q;

    exec_ctrl_dec u_dec (
        .op_code (op_code),
        .fn_code (fn_code),
        .a_src   (a_src),
        .b_src   (b_src),
        .alu_fn  (alu_fn),
        .set_cc  (set_cc),
        .is_jump (is_jump)
    );

    exec_operand_sel #(.W(W), .STEP(STEP)) u_sel (
        .a_src     (a_src),
        .b_src     (b_src),
        .reg_a     (reg_a),
        .reg_b     (reg_b),
        .const_val (const_val),
        .alu_a     (alu_a),
        .alu_b     (alu_b)
    );

    exec_alu #(.W(W)) u_alu (
        .fn         (alu_fn),
        .a          (alu_a),
        .b          (alu_b),
        .y          (result),
        .flags_next (flags_next)
    );

    exec_cc_branch u_cc (
        .clk         (clk),
        .rst         (rst),
        .load        (set_cc),
        .flags_next  (flags_next),
        .is_jump     (is_jump),
        .fn_code     (fn_code),
        .cc_q        (cc_q),
        .take_branch (take_branch)
    );

endmodule

// File: rtl/exec_stage_chk.sv
module exec_stage_chk #(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [3:0]   op_code,
    input logic [3:0]   fn_code,
    input logic [W-1:0] reg_b,
    input logic [W-1:0] const_val,
    input logic [W-1:0] result,
    input logic         take_branch,
    input logic [2:0]   cc_q
);

    localparam logic [W-1:0] STEP_W = W'(STEP);

    // R7
    p_cc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (op_code != 4'd6) |=> $stable(cc_q));

    // R5
    p_zero_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'd6) |=> (cc_q[2] == ($past(result) == '0)));

    // R5
    p_sign_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'd6) |=> (cc_q[1] == $past(result[W-1])));

    // R6
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'd6 && (fn_code == 4'd2 || fn_code == 4'd3)) |=> !cc_q[0]);

    // R4
    p_eff_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'd4 || op_code == 4'd5) |-> (result == reg_b + const_val));

    // R4
    p_stack_dec_r4: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'd8 || op_code == 4'd10) |-> (result == reg_b - STEP_W));

    // R9
    p_eq_cond_r9: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'd7 && fn_code == 4'd3) |-> (take_branch == cc_q[2]));

    // R10
    p_no_branch_r10: assert property (@(posedge clk) disable iff (rst)
        (op_code != 4'd7) |-> !take_branch);

endmodule

bind exec_stage exec_stage_chk #(.W(W), .STEP(STEP)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_code     (op_code),
    .fn_code     (fn_code),
    .reg_b       (reg_b),
    .const_val   (const_val),
    .result      (result),
    .take_branch (take_branch),
    .cc_q        (cc_q)
);

// File: tb/sim_exec_stage.sv
`timescale 1ns/1ps
module sim_exec_stage;

    localparam int CLK_PERIOD = 20;
    localparam int W    = 8;
    localparam int STEP = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   op_code = 4'd1;
    logic [3:0]   fn_code = 4'd0;
    logic [W-1:0] reg_a = '0;
    logic [W-1:0] reg_b = '0;
    logic [W-1:0] const_val = '0;
    logic [W-1:0] result;
    logic         take_branch;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit m_zf = 1;
    bit m_sf = 0;
    bit m_of = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exec_stage #(.W(W), .STEP(STEP)) u0 (
        .clk         (clk),
        .rst         (rst),
        .op_code     (op_code),
        .fn_code     (fn_code),
        .reg_a       (reg_a),
        .reg_b       (reg_b),
        .const_val   (const_val),
        .result      (result),
        .take_branch (take_branch)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (op %0d fn %0d a %0d b %0d c %0d)",
                     req, act, exp, op_code, fn_code, reg_a, reg_b, const_val);
        end
    endtask

    function automatic int sx(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // ALU model for opcode 6: returns result, sets flags (R3, R5, R6)
    task automatic model_alu(input int fn, input int a, input int b,
                             output int r, output bit z, output bit s, output bit o);
        int wide;
        o = 0;
        case (fn)
            1: begin wide = sx(b) - sx(a); o = (wide > 127) || (wide < -128); r = wide & 255; end
            2: r = a & b;
            3: r = a ^ b;
            default: begin wide = sx(b) + sx(a); o = (wide > 127) || (wide < -128); r = wide & 255; end
        endcase
        z = (r == 0);
        s = r[7];
    endtask

    // Non-ALU opcode result model (R1, R2, R4)
    function automatic int exp_res(input int op, input int a, input int b, input int c);
        case (op)
            2:      return a;
            3:      return c;
            4, 5:   return (b + c) & 255;
            8, 10:  return (b - STEP) & 255;
            9, 11:  return (b + STEP) & 255;
            default: return 0;
        endcase
    endfunction

    function automatic bit br_exp(input int code, input bit z, input bit s, input bit o);
        bit lt;
        lt = s ^ o;
        case (code)
            0: return 1;
            1: return lt | z;
            2: return lt;
            3: return z;
            4: return !z;
            5: return !lt;
            6: return !(lt | z);
            default: return 0;
        endcase
    endfunction

    // Sweep all jump codes against model flags; called mid-cycle, ends before next edge
    task automatic sweep_jump(input string req);
        op_code = 4'd7;
        for (int c = 0; c < 16; c++) begin
            fn_code = 4'(c);
            #0.5;
            chk(take_branch == br_exp(c, m_zf, m_sf, m_of), req,
                int'(take_branch), int'(br_exp(c, m_zf, m_sf, m_of)));
        end
        op_code = 4'd1;
    endtask

    task automatic alu_step(input int fn, input int a, input int b);
        int r;
        bit z, s, o;
        @(negedge clk);
        op_code = 4'd6; fn_code = 4'(fn); reg_a = 8'(a); reg_b = 8'(b); const_val = 8'h5A;
        #1;
        model_alu(fn, a, b, r, z, s, o);
        chk(result == 8'(r), "R3", int'(result), r);
        @(posedge clk);
        m_zf = z; m_sf = s; m_of = o;
        #1;
        sweep_jump("R5/R6/R9");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8: reset flags are zero set, others clear
        #1;
        sweep_jump("R8");

        // R3/R5/R6/R9: near-exhaustive ALU sweep
        for (int fn = 0; fn < 4; fn++) begin
            for (int a = 0; a < 256; a++) begin
                for (int k = 0; k < 19; k++) begin
                    int b;
                    b = (k < 16) ? k * 17 : (k == 16) ? 8'h7F : (k == 17) ? 8'h80 : 8'h01;
                    alu_step(fn, a, b);
                end
            end
        end

        // R3: function codes above 3 add
        alu_step(9, 8'h70, 8'h20);
        alu_step(15, 8'hFF, 8'h01);

        // Known flags: 0x7F + 0x01 -> 0x80, sign and overflow set
        alu_step(0, 8'h01, 8'h7F);

        // R1/R2/R4/R10/R7: every non-ALU opcode, across clock edges
        for (int set = 0; set < 2; set++) begin
            for (int op = 0; op < 16; op++) begin
                int a, b, c, e;
                if (op == 6) continue;
                a = set ? 8'hC4 : 8'h35;
                b = set ? 8'h02 : 8'hC2;
                c = set ? 8'hFF : 8'h1B;
                @(negedge clk);
                op_code = 4'(op); fn_code = 4'd0;
                reg_a = 8'(a); reg_b = 8'(b); const_val = 8'(c);
                #1;
                e = exp_res(op, a, b, c);
                if (op == 7) begin
                    chk(take_branch == 1'b1, "R9", int'(take_branch), 1);
                end else begin
                    chk(result == 8'(e), "R1/R2/R4", int'(result), e);
                    chk(take_branch == 1'b0, "R10", int'(take_branch), 0);
                end
                @(posedge clk);
                #1;
            end
            sweep_jump("R7");
        end

        // R8: synchronous reset mid-run restores reset flags
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        m_zf = 1; m_sf = 0; m_of = 0;
        sweep_jump("R8");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule